// File: doc/BRIEF.md
# Logarithmic Approximate Unsigned Multiplier

This block multiplies two unsigned integers approximately. It does not build and sum a partial-product array. It uses the identity log(a·b) = log a + log b.

- **Log estimate.** For each operand a leading-one detector finds the bit position k. That position is the integer part of a piecewise-linear base-2 logarithm. A barrel shift left-aligns the bits below the leading one into a fraction x, so that the operand is read as 2^k·(1+x), linear between consecutive powers of two.
- **Adding the estimates.** The two characteristics are added, and the two fractions are added.
- **Antilog.** A linear antilog, 1 plus the fraction, is shifted by the summed characteristic to give the product.

A design-time parameter sets how many fraction bits below the leading one are kept. Fewer bits mean a smaller adder and antilog path but a larger error. Every approximation step rounds toward zero, so the result is never above the exact product.

Operands arrive with a valid strobe. The product appears one clock later in a register, together with its own valid flag. The block suits error-tolerant datapaths such as neural-network inference, where a small, one-sided, bounded multiplication error is acceptable in exchange for far less logic.

Top module: `log_approx_mul`

## Requirements
- R1: While `rst` is sampled high at a rising edge, `out_valid` and `product` are 0 after that edge.
- R2: `out_valid` after each rising edge equals `in_valid` sampled at that edge.
- R3: When `in_valid` is low at a rising edge, `product` keeps its previous value whatever the operands are.
- R4: When `in_valid` is high and either operand is 0, `product` becomes exactly 0 after the edge.
- R5: For nonzero operands, write each operand v as leading-one position k plus the W-1 bits below it. Left-align those bits in a W-1 bit fraction field and clear all but its top FRAC_BITS bits. The product is floor((2^(W-1) + xa + xb)·2^(ka+kb) / 2^(W-1)) when xa+xb < 2^(W-1).
- R6: When the two fraction fields sum to 2^(W-1) or more, the characteristic sum is incremented by one and the fraction becomes the sum minus 2^(W-1) before the antilog of R5 is applied.
- R7: For any operands, `product` is never greater than the exact product op_a·op_b.
- R8: If either operand is a nonzero power of two, the product is exact when FRAC_BITS = W-1. If both are, it is exact for any FRAC_BITS.
- R9: With FRAC_BITS = W-1, for all nonzero operand pairs, 9·(exact − product) ≤ exact, so the relative error is at most 1/9.
- R10: With FRAC_BITS = 0, the product of nonzero operands is exactly 2^(ka+kb).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | OPND_W | First unsigned operand |
| op_b | input | OPND_W | Second unsigned operand |
| out_valid | output | 1 | `product` holds a new result |
| product | output | 2*OPND_W | Registered approximate product |

## Verification
The bench builds three copies with OPND_W = 8 and FRAC_BITS set to 7, 3 and 0. All three are driven with the same stimulus.

- **FRAC_BITS = 7.** Every fraction bit is kept, which brings the full-precision 1/9 error bound and the power-of-two exactness within reach.
- **FRAC_BITS = 3.** Fraction truncation matters here: carries out of the fraction sum occur on shortened fields.
- **FRAC_BITS = 0.** Only the characteristic remains, giving the pure power-of-two result.

An 8-bit width keeps an exhaustive sweep of all 65,536 operand pairs affordable. That sweep includes zeros, both extremes and every fraction-carry case. Idle cycles with changing operands are interleaved to exercise result holding.

// File: rtl/log_mul_pkg.sv
package log_mul_pkg;

    // Upper bound on operand width handled by the helper functions
    localparam int MAX_OPND_W = 32;

    // Which path produced the registered result
    typedef enum logic {
        SRC_ZERO = 1'b0,
        SRC_LOG  = 1'b1
    } prod_src_e;

    // Position of the highest set bit (0 when none is set)
    function automatic int msb_index(input logic [MAX_OPND_W-1:0] v);
        int r;
        r = 0;
        for (int i = 0; i < MAX_OPND_W; i++) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

    // Mask that keeps the top 'keep' bits of a 'field_w'-bit fraction field
    function automatic logic [MAX_OPND_W-1:0] keep_mask(input int field_w, input int keep);
        logic [MAX_OPND_W-1:0] m;
        m = '1;
        m = m << (field_w - keep);
        return m;
    endfunction

endpackage

// File: rtl/log_mul_lod.sv
// Leading-one detection and fraction alignment for one operand
module log_mul_lod
    import log_mul_pkg::*;
#(
    parameter int OPND_W = 8,
    parameter int KEEP   = 7
) (
    input  logic [OPND_W-1:0]         opnd,
    output logic [$clog2(OPND_W)-1:0] chr,
    output logic [OPND_W-2:0]         frac
);
    localparam int KW = $clog2(OPND_W);
    localparam int FW = OPND_W - 1;
    localparam logic [MAX_OPND_W-1:0] TRUNC = keep_mask(FW, KEEP);

    logic [MAX_OPND_W-1:0] wide;
    logic [KW-1:0]         shamt;
    logic [OPND_W-1:0]     aligned;
    int                    pos;

    assign wide = MAX_OPND_W'(opnd);

    always_comb begin
        pos     = msb_index(wide);
        chr     = KW'(pos);
        shamt   = KW'(FW - pos);
        aligned = opnd << shamt;
        frac    = aligned[FW-1:0] & TRUNC[FW-1:0];
    end

endmodule

// File: rtl/log_mul_antilog.sv
// Linear antilog: (1 + fraction) shifted by the summed characteristic
module log_mul_antilog #(
    parameter int OPND_W = 8
) (
    input  logic [$clog2(OPND_W):0] ksum,
    input  logic [OPND_W-1:0]       fsum,
    output logic [2*OPND_W-1:0]     prod
);
    localparam int KW = $clog2(OPND_W);
    localparam int FW = OPND_W - 1;
    localparam int TW = 3 * OPND_W;

    logic [KW:0]       kk;
    logic [OPND_W-1:0] one_frac;
    logic [TW-1:0]     scaled;

    always_comb begin
        // a carry out of the fraction sum moves one unit into the characteristic;
        // the remaining fraction is the low bits in both cases
        kk       = ksum + (KW+1)'(fsum[FW]);
        one_frac = {1'b1, fsum[FW-1:0]};
        scaled   = TW'(one_frac) << kk;
        prod     = (2*OPND_W)'(scaled >> FW);
    end

endmodule

// File: rtl/log_approx_mul.sv
module log_approx_mul
    import log_mul_pkg::*;
#(
    parameter int OPND_W    = 8,
    parameter int FRAC_BITS = OPND_W - 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [OPND_W-1:0]     op_a,
    input  logic [OPND_W-1:0]     op_b,
    output logic                  out_valid,
    output logic [2*OPND_W-1:0]   product
);
    localparam int KW   = $clog2(OPND_W);
    localparam int FW   = OPND_W - 1;
    localparam int KEEP = (FRAC_BITS > FW) ? FW : ((FRAC_BITS < 0) ? 0 : FRAC_BITS);

    logic [OPND_W-1:0] opnd_arr [2];
    logic [KW-1:0]     chr_arr  [2];
    logic [FW-1:0]     frac_arr [2];

    assign opnd_arr[0] = op_a;
    assign opnd_arr[1] = op_b;

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        log_mul_lod #(
            .OPND_W (OPND_W),
            .KEEP   (KEEP)
        ) u_lod (
            .opnd (opnd_arr[g]),
            .chr  (chr_arr[g]),
            .frac (frac_arr[g])
        );
    end

    logic [KW:0]         ksum;
    logic [OPND_W-1:0]   fsum;
    logic [2*OPND_W-1:0] log_prod;
    logic [2*OPND_W-1:0] next_prod;
    prod_src_e           src;

    assign ksum = {1'b0, chr_arr[0]} + {1'b0, chr_arr[1]};
    assign fsum = {1'b0, frac_arr[0]} + {1'b0, frac_arr[1]};

    log_mul_antilog #(
        .OPND_W (OPND_W)
    ) u_antilog (
        .ksum (ksum),
        .fsum (fsum),
        .prod (log_prod)
    );

    always_comb begin
        src       = ((op_a == '0) || (op_b == '0)) ? SRC_ZERO : SRC_LOG;
        next_prod = (src == SRC_ZERO) ? '0 : log_prod;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) product <= next_prod;
        end
    end

endmodule

// File: rtl/log_approx_mul_chk.sv
module log_approx_mul_chk #(
    parameter int OPND_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [OPND_W-1:0]   op_a,
    input logic [OPND_W-1:0]   op_b,
    input logic                out_valid,
    input logic [2*OPND_W-1:0] product
);
    logic [2*OPND_W-1:0] exact_q;

    always_ff @(posedge clk) begin
        exact_q <= (2*OPND_W)'(op_a) * (2*OPND_W)'(op_b);
    end

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && product == '0));

    // R2
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(product));

    // R4
    p_zero_opnd_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_a == '0 || op_b == '0)) |=> product == '0);

    // R7
    p_not_above_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> product <= exact_q);

    // R8
    p_pow2_exact_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && $countones(op_a) == 1 && $countones(op_b) == 1) |=> product == exact_q);

endmodule

bind log_approx_mul log_approx_mul_chk #(.OPND_W(OPND_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/log_approx_mul_bench.sv
module log_approx_mul_bench;

    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;

    logic v7, v3, v0;
    logic [2*W-1:0] p7, p3, p0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    log_approx_mul #(.OPND_W(W), .FRAC_BITS(7)) u_log_approx_mul (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(v7), .product(p7));
    log_approx_mul #(.OPND_W(W), .FRAC_BITS(3)) u_log_approx_mul_f3 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(v3), .product(p3));
    log_approx_mul #(.OPND_W(W), .FRAC_BITS(0)) u_log_approx_mul_f0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(v0), .product(p0));

    // Behavioural model of the requirement formulas
    function automatic longint model(input int a, input int b, input int keep, output bit carry);
        int ka, kb, fa, fb, s, k, drop;
        carry = 0;
        if (a == 0 || b == 0) return 0;
        ka = 0; kb = 0;
        for (int i = 0; i < W; i++) begin
            if ((a >> i) & 1) ka = i;
            if ((b >> i) & 1) kb = i;
        end
        drop = (W - 1) - keep;
        fa = ((a - (1 << ka)) << ((W - 1) - ka));
        fb = ((b - (1 << kb)) << ((W - 1) - kb));
        fa = (fa >> drop) << drop;
        fb = (fb >> drop) << drop;
        s = fa + fb;
        k = ka + kb;
        if (s >= (1 << (W - 1))) begin
            carry = 1;
            k = k + 1;
            s = s - (1 << (W - 1));
        end
        return ((longint'(1 << (W - 1)) + s) << k) >> (W - 1);
    endfunction

    function automatic bit is_pow2(input int v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected state
    bit     exp_valid = 0;
    longint exp7 = 0, exp3 = 0, exp0 = 0;
    bit     c7 = 0, c3 = 0, c0 = 0;
    int     last_a = 0, last_b = 0;
    bit     last_live = 0;

    task automatic step(input bit v, input int a, input int b);
        longint exact;
        string  t;
        @(negedge clk);
        // compare outputs from the previous edge
        check(v7 == exp_valid, "R2", longint'(v7), longint'(exp_valid));
        check(v3 == exp_valid, "R2", longint'(v3), longint'(exp_valid));
        check(v0 == exp_valid, "R2", longint'(v0), longint'(exp_valid));
        if (!exp_valid) begin
            check(longint'(p7) == exp7, "R3", longint'(p7), exp7);
            check(longint'(p3) == exp3, "R3", longint'(p3), exp3);
            check(longint'(p0) == exp0, "R3", longint'(p0), exp0);
        end else begin
            exact = longint'(last_a) * longint'(last_b);
            if (last_a == 0 || last_b == 0) begin
                check(longint'(p7) == 0, "R4", longint'(p7), 0);
                check(longint'(p3) == 0, "R4", longint'(p3), 0);
                check(longint'(p0) == 0, "R4", longint'(p0), 0);
            end else begin
                t = c7 ? "R6" : "R5";
                check(longint'(p7) == exp7, t, longint'(p7), exp7);
                t = c3 ? "R6" : "R5";
                check(longint'(p3) == exp3, t, longint'(p3), exp3);
                check(longint'(p0) == exp0, "R10", longint'(p0), exp0);
                check(9 * (exact - longint'(p7)) <= exact, "R9", longint'(p7), exact);
                if (is_pow2(last_a) || is_pow2(last_b))
                    check(longint'(p7) == exact, "R8", longint'(p7), exact);
                if (is_pow2(last_a) && is_pow2(last_b)) begin
                    check(longint'(p3) == exact, "R8", longint'(p3), exact);
                    check(longint'(p0) == exact, "R8", longint'(p0), exact);
                end
            end
            check(longint'(p7) <= exact, "R7", longint'(p7), exact);
            check(longint'(p3) <= exact, "R7", longint'(p3), exact);
            check(longint'(p0) <= exact, "R7", longint'(p0), exact);
        end
        // drive the next cycle
        in_valid = v;
        op_a = W'(a);
        op_b = W'(b);
        exp_valid = v;
        if (v) begin
            exp7 = model(a, b, 7, c7);
            exp3 = model(a, b, 3, c3);
            exp0 = model(a, b, 0, c0);
            last_a = a;
            last_b = b;
        end
    endtask

    initial begin
        int n;
        n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(v7 == 0 && v3 == 0 && v0 == 0, "R1", longint'(v7), 0);
        check(p7 == 0 && p3 == 0 && p0 == 0, "R1", longint'(p7), 0);
        rst = 0;
        // directed corners
        step(1, 3, 3);     // R6 carry: 8 at full precision
        step(1, 6, 6);     // R6 carry
        step(1, 0, 200);   // R4
        step(1, 255, 0);   // R4
        step(1, 128, 128); // R8 exact
        step(1, 255, 255);
        step(0, 77, 91);   // R3 hold
        step(0, 0, 0);     // R3 hold
        step(1, 1, 1);
        // exhaustive sweep with interleaved idle cycles
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                n++;
                if (n % 53 == 0) step(0, a ^ 8'h5a, b ^ 8'ha5);
                step(1, a, b);
            end
        end
        step(0, 0, 0);
        step(0, 0, 0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule